// File: doc/BRIEF.md
# Dual-Mode HDLC Frame Transmitter

This block serializes bytes for one 64 kbit/s B channel. A host pushes bytes into an internal transmit FIFO through a one-cycle write strobe. The serializer produces one line bit for each cycle in which the bit-clock enable is high. The line bit is registered, so it changes only on those cycles. A mode input chooses between two formats. The framed format brackets each message with flag octets, inserts a zero after any five consecutive ones and appends a CRC-16 check sequence. The raw format streams FIFO bytes exactly as written.

The host controls the serializer with two single-cycle command pulses. The end pulse closes a framed message once its data is drained, or halts a raw stream at the next byte boundary. The reset pulse flushes the FIFO and puts the line back in its idle state. A ready output tells the host that at least half of the FIFO is free. A fill-select input picks the framed-mode idle pattern: continuous ones, or back-to-back flags.

Top module: `hdlc_dual_tx`

## Requirements
- R1: After reset `txBit` is 1, `fifoReady` is 1, the FIFO is empty and the serializer is idle with its fill-byte bit position at 0.
- R2: In framed mode a message goes out as follows. First an opening flag 0x7E. Then each FIFO byte, least significant bit first. Then the ones' complement of a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF, computed over the data bits), least significant bit first. Then a closing flag. The CRC and closing flag follow only once the FIFO is empty at a byte boundary and an end command is pending.
- R3: In framed mode a 0 is inserted after every run of five consecutive 1s inside data and CRC bits, including a run that ends the CRC. The inserted bit does not enter the CRC and does not consume a data bit. Flags and fill bits are never stuffed.
- R4: In raw mode each FIFO byte is sent least significant bit first with no flags, stuffing or CRC. Bytes are sent back to back while the FIFO holds data. The line idles at 1.
- R5: In raw mode a pending end command takes effect after the last bit of the current byte. The remaining FIFO content is discarded, the end command is consumed and the line returns to idle 1s.
- R6: In framed mode, with `fillFlag`=0 the idle line sends 1s; with `fillFlag`=1 it sends repeated 0x7E, least significant bit first. Idle bits advance a 0..7 bit position, and a message or raw stream starts only when that position is 0 and the FIFO is non-empty.
- R7: If the FIFO is empty at a byte boundary of a framed message and no end command is pending, the frame is aborted. The line sends eight 1s and then returns to fill.
- R8: A reset pulse flushes the FIFO and returns the serializer to idle at bit position 0. It drops any pending end command, and it drops a host write in the same cycle. `fifoReady` is 1 in the next cycle.
- R9: `fifoReady` is 1 exactly when the FIFO holds at most DEPTH/2 bytes.
- R10: `txBit` changes only in a cycle with `bitEn`=1 and no reset pulse. In all other cycles it holds.
- R11: A host write while the FIFO holds DEPTH bytes is ignored.
- R12: `rawMode` and `fillFlag` are used only while idle, so changing `rawMode` during a message has no effect on that message. An end command given while idle with an empty FIFO is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bitEn | input | 1 | Bit-clock enable: one line bit per high cycle |
| rawMode | input | 1 | 1 selects raw streaming, 0 selects framed mode |
| fillFlag | input | 1 | Framed idle pattern: 0 ones, 1 flags |
| wrEn | input | 1 | Host write strobe into the FIFO |
| wrData | input | DATA_W | Byte written with `wrEn` |
| cmdEnd | input | 1 | End-of-message command pulse |
| cmdReset | input | 1 | Transmitter reset command pulse |
| txBit | output | 1 | Serial line bit |
| fifoReady | output | 1 | At least half of the FIFO is free |

## Verification
The bench builds the block with DEPTH=8 and DATA_W=8. The shallow FIFO lets a handful of writes reach the half-full ready threshold and the full condition where writes are dropped, with the bit clock held off. A behavioural model is compared with the ports on every cycle. Its stimulus includes all-ones bytes that force stuffing inside data and CRC, an underrun abort, a raw stream cut short by an end command, a reset pulse during a message, a mode change in the middle of a frame, and bit-enable rates of one in one, two, three and four cycles.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam logic [7:0]  FLAG_PAT     = 8'h7E;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic [1:0] {SEL_CONST, SEL_DATA, SEL_HEAD, SEL_CRC} outSel_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RAW, ST_OPEN, ST_DATA, ST_CRC, ST_CLOSE, ST_ABORT
  } txState_t;

  typedef struct packed {
    logic    step;
    outSel_t sel;
    logic    constBit;
    logic    pop;
    logic    flush;
    logic    loadData;
    logic    loadHeadShift;
    logic    shiftData;
    logic    crcInit;
    logic    crcUpd;
    logic    loadCrc;
    logic    shiftCrc;
    logic    onesClr;
    logic    onesCount;
  } txStrobe_t;

endpackage

// File: rtl/hdlc_tx_dp.sv
module hdlc_tx_dp
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         stb,
  output logic              empty,
  output logic              onesFive,
  output logic              txBit,
  output logic              fifoReady
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] head, shData;
  logic [15:0]       crcReg, crcNext, crcSh;
  logic [2:0]        ones;
  logic              wrOk, outBit, fb;

  assign wrOk      = wrEn && !stb.flush && (count < FULL_CNT);
  assign head      = mem[rdPtr];
  assign empty     = (count == '0);
  assign fifoReady = (count <= HALF_CNT);
  assign onesFive  = (ones == 3'd5);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (stb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (wrOk)    wrPtr <= bump(wrPtr);
      if (stb.pop) rdPtr <= bump(rdPtr);
      case ({wrOk, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fb      = crcReg[0] ^ shData[0];
  assign crcNext = {1'b0, crcReg[15:1]} ^ (fb ? CRC_POLY_REV : 16'h0000);

  always_comb begin
    unique case (stb.sel)
      SEL_DATA: outBit = shData[0];
      SEL_HEAD: outBit = head[0];
      SEL_CRC:  outBit = crcSh[0];
      default:  outBit = stb.constBit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBit  <= 1'b1;
      shData <= '0;
      crcReg <= 16'hFFFF;
      crcSh  <= '0;
      ones   <= '0;
    end else begin
      if (stb.step) txBit <= outBit;
      if (stb.loadData)           shData <= head;
      else if (stb.loadHeadShift) shData <= head >> 1;
      else if (stb.shiftData)     shData <= shData >> 1;
      if (stb.crcInit)     crcReg <= 16'hFFFF;
      else if (stb.crcUpd) crcReg <= crcNext;
      if (stb.loadCrc)       crcSh <= ~(stb.crcUpd ? crcNext : crcReg);
      else if (stb.shiftCrc) crcSh <= crcSh >> 1;
      if (stb.onesClr)        ones <= '0;
      else if (stb.onesCount) ones <= outBit ? ones + 3'd1 : 3'd0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R11

  AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    stb.flush |=> fifoReady); // R8

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pop |-> (count != '0)); // R4

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bitEn,
  input  logic      rawMode,
  input  logic      fillFlag,
  input  logic      cmdEnd,
  input  logic      cmdReset,
  input  logic      empty,
  input  logic      onesFive,
  input  logic      txBitMon,
  output txStrobe_t stb
);

  localparam logic [3:0] LAST_BIT = 4'(DATA_W - 1);
  localparam logic [3:0] LAST_CRC = 4'd15;

  txState_t   state, stNext;
  logic [3:0] cnt, cntNext;
  logic       endPend, endClr, fetchNext, flagBit, lastBit;

  assign flagBit = FLAG_PAT[cnt[2:0]];
  assign lastBit = (cnt == LAST_BIT);

  always_comb begin
    stb       = '0;
    stNext    = state;
    cntNext   = cnt;
    endClr    = 1'b0;
    fetchNext = 1'b0;
    if (cmdReset) begin
      stb.flush   = 1'b1;
      stb.onesClr = 1'b1;
      stNext      = ST_IDLE;
      cntNext     = '0;
    end else if (bitEn) begin
      stb.step = 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (cnt == '0 && !empty) begin
            if (rawMode) begin
              stb.sel           = SEL_HEAD;
              stb.pop           = 1'b1;
              stb.loadHeadShift = 1'b1;
              stNext            = ST_RAW;
            end else begin
              stb.constBit = 1'b0;
              stb.crcInit  = 1'b1;
              stb.onesClr  = 1'b1;
              stNext       = ST_OPEN;
            end
            cntNext = 4'd1;
          end else begin
            stb.constBit = (rawMode || !fillFlag) ? 1'b1 : flagBit;
            cntNext      = lastBit ? '0 : cnt + 4'd1;
            if (empty) endClr = 1'b1;
          end
        end
        ST_RAW: begin
          stb.sel       = SEL_DATA;
          stb.shiftData = 1'b1;
          cntNext       = cnt + 4'd1;
          if (lastBit) begin
            cntNext = '0;
            if (endPend) begin
              stb.flush = 1'b1;
              endClr    = 1'b1;
              stNext    = ST_IDLE;
            end else if (!empty) begin
              stb.pop      = 1'b1;
              stb.loadData = 1'b1;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        ST_OPEN: begin
          stb.constBit = flagBit;
          cntNext      = cnt + 4'd1;
          fetchNext    = lastBit;
        end
        ST_DATA: begin
          if (onesFive) begin
            stb.onesClr = 1'b1;
          end else begin
            stb.sel       = SEL_DATA;
            stb.shiftData = 1'b1;
            stb.crcUpd    = 1'b1;
            stb.onesCount = 1'b1;
            cntNext       = cnt + 4'd1;
            fetchNext     = lastBit;
          end
        end
        ST_CRC: begin
          if (onesFive) begin
            stb.onesClr = 1'b1;
          end else begin
            stb.sel       = SEL_CRC;
            stb.shiftCrc  = 1'b1;
            stb.onesCount = 1'b1;
            cntNext       = cnt + 4'd1;
            if (cnt == LAST_CRC) begin
              stNext  = ST_CLOSE;
              cntNext = '0;
            end
          end
        end
        ST_CLOSE: begin
          stb.onesClr = 1'b1;
          if (!onesFive) begin
            stb.constBit = flagBit;
            cntNext      = cnt + 4'd1;
            if (lastBit) begin
              stNext  = ST_IDLE;
              cntNext = '0;
            end
          end
        end
        default: begin
          stb.constBit = 1'b1;
          stb.onesClr  = 1'b1;
          cntNext      = cnt + 4'd1;
          if (lastBit) begin
            stNext  = ST_IDLE;
            cntNext = '0;
          end
        end
      endcase
      if (fetchNext) begin
        cntNext = '0;
        if (!empty) begin
          stb.pop      = 1'b1;
          stb.loadData = 1'b1;
          stNext       = ST_DATA;
        end else if (endPend) begin
          stb.loadCrc = 1'b1;
          endClr      = 1'b1;
          stNext      = ST_CRC;
        end else begin
          stNext = ST_ABORT;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      endPend <= 1'b0;
    end else begin
      state <= stNext;
      cnt   <= cntNext;
      if (cmdReset)    endPend <= 1'b0;
      else if (cmdEnd) endPend <= 1'b1;
      else if (endClr) endPend <= 1'b0;
    end
  end

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bitEn || cmdReset) |=> $stable(txBitMon)); // R10

  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ABORT && bitEn && !cmdReset) |=> txBitMon); // R7

  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_DATA || state == ST_CRC || state == ST_CLOSE) && onesFive
      && bitEn && !cmdReset) |=> !txBitMon); // R3

  AST_RAW_IDLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && rawMode && empty && bitEn && !cmdReset) |=> txBitMon); // R4

endmodule

// File: rtl/hdlc_dual_tx.sv
module hdlc_dual_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitEn,
  input  logic              rawMode,
  input  logic              fillFlag,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cmdEnd,
  input  logic              cmdReset,
  output logic              txBit,
  output logic              fifoReady
);

  txStrobe_t stb;
  logic      empty, onesFive;

  hdlc_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bitEn    (bitEn),
    .rawMode  (rawMode),
    .fillFlag (fillFlag),
    .cmdEnd   (cmdEnd),
    .cmdReset (cmdReset),
    .empty    (empty),
    .onesFive (onesFive),
    .txBitMon (txBit),
    .stb      (stb)
  );

  hdlc_tx_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .stb       (stb),
    .empty     (empty),
    .onesFive  (onesFive),
    .txBit     (txBit),
    .fifoReady (fifoReady)
  );

endmodule

// File: tb/hdlc_dual_tx_tb.sv
`timescale 1ns/1ps
module hdlc_dual_tx_tb;

  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bitEn = 1'b0;
  logic       rawMode = 1'b0;
  logic       fillFlag = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       cmdEnd = 1'b0;
  logic       cmdReset = 1'b0;
  logic       txBit, fifoReady;

  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  int    bePeriod = 0;
  bit    checking = 0;
  bit    done = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  hdlc_dual_tx #(.DATA_W(8), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .rawMode(rawMode),
    .fillFlag(fillFlag), .wrEn(wrEn), .wrData(wrData), .cmdEnd(cmdEnd),
    .cmdReset(cmdReset), .txBit(txBit), .fifoReady(fifoReady)
  );

  always @(negedge clk) begin
    cyc++;
    bitEn = (bePeriod > 0) && (cyc % bePeriod == 0);
  end

  // behavioural reference model
  logic [7:0] q[$];
  int  mSt, mCnt, mSh, mCrc, mCsh, mOnes;
  bit  mEnd, expTx, expReady;

  function automatic int crcStep(int c, int d);
    int f;
    f = (c ^ d) & 1;
    c = c >> 1;
    if (f != 0) c = c ^ 'h8408;
    return c;
  endfunction

  function automatic bit flagAt(int i);
    return bit'((8'h7E >> i) & 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      mSt = 0; mCnt = 0; mOnes = 0; mEnd = 0; mSh = 0; mCrc = 'hFFFF; mCsh = 0;
      expTx = 1; expReady = 1;
    end else begin
      int  preSize;
      bit  emp, flushed, endNext, fetch;
      preSize = q.size();
      emp = (preSize == 0);
      flushed = 0;
      endNext = mEnd;
      fetch = 0;
      if (cmdReset) begin
        q.delete(); flushed = 1; mSt = 0; mCnt = 0; mOnes = 0; endNext = 0;
      end else if (bitEn) begin
        case (mSt)
          0: begin
            if (mCnt == 0 && !emp) begin
              if (rawMode) begin
                mSh = int'(q.pop_front()); expTx = bit'(mSh & 1); mSh = mSh >> 1; mSt = 1;
              end else begin
                expTx = 0; mCrc = 'hFFFF; mOnes = 0; mSt = 2;
              end
              mCnt = 1;
            end else begin
              expTx = (rawMode || !fillFlag) ? 1'b1 : flagAt(mCnt);
              mCnt = (mCnt + 1) % 8;
              if (emp) endNext = 0;
            end
          end
          1: begin
            expTx = bit'(mSh & 1); mSh = mSh >> 1;
            if (mCnt == 7) begin
              mCnt = 0;
              if (mEnd) begin q.delete(); flushed = 1; endNext = 0; mSt = 0; end
              else if (!emp) mSh = int'(q.pop_front());
              else mSt = 0;
            end else mCnt++;
          end
          2: begin
            expTx = flagAt(mCnt);
            if (mCnt == 7) fetch = 1; else mCnt++;
          end
          3: begin
            if (mOnes == 5) begin expTx = 0; mOnes = 0; end
            else begin
              expTx = bit'(mSh & 1);
              mCrc = crcStep(mCrc, mSh & 1);
              mOnes = expTx ? mOnes + 1 : 0;
              mSh = mSh >> 1;
              if (mCnt == 7) fetch = 1; else mCnt++;
            end
          end
          4: begin
            if (mOnes == 5) begin expTx = 0; mOnes = 0; end
            else begin
              expTx = bit'(mCsh & 1);
              mOnes = expTx ? mOnes + 1 : 0;
              mCsh = mCsh >> 1;
              if (mCnt == 15) begin mSt = 5; mCnt = 0; end else mCnt++;
            end
          end
          5: begin
            if (mOnes == 5) begin expTx = 0; mOnes = 0; end
            else begin
              expTx = flagAt(mCnt); mOnes = 0;
              if (mCnt == 7) begin mSt = 0; mCnt = 0; end else mCnt++;
            end
          end
          default: begin
            expTx = 1; mOnes = 0;
            if (mCnt == 7) begin mSt = 0; mCnt = 0; end else mCnt++;
          end
        endcase
        if (fetch) begin
          mCnt = 0;
          if (!emp) begin mSh = int'(q.pop_front()); mSt = 3; end
          else if (mEnd) begin mCsh = (~mCrc) & 'hFFFF; endNext = 0; mSt = 4; end
          else mSt = 6;
        end
      end
      mEnd = cmdReset ? 1'b0 : (cmdEnd ? 1'b1 : endNext);
      if (wrEn && !flushed && preSize < DEPTH) q.push_back(wrData);
      expReady = (q.size() <= DEPTH / 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      vectors++;
      if (txBit !== expTx || fifoReady !== expReady) begin
        miscompares++;
        $display("FAIL %s cycle %0d: txBit=%b fifoReady=%b expected txBit=%b fifoReady=%b",
                 curReq, cyc, txBit, fifoReady, expTx, expReady);
      end
    end
  end

  task automatic checkBit(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wrEn = 1; wrData = b;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic pulseEnd();
    @(negedge clk); cmdEnd = 1;
    @(negedge clk); cmdEnd = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    run(4);
    rst_n = 1;
    checking = 1;
    @(negedge clk);
    checkBit("R1 txBit after reset", txBit, 1'b1);
    checkBit("R1 fifoReady after reset", fifoReady, 1'b1);
    bePeriod = 1;
    run(20);

    // R2 framed message with mark fill
    curReq = "R2"; bePeriod = 0; fillFlag = 0; rawMode = 0;
    wr(8'h12); wr(8'hA5); wr(8'h3C); pulseEnd();
    bePeriod = 1; run(90);

    // R3 stuffing in data and CRC, flag fill
    curReq = "R3"; bePeriod = 0; fillFlag = 1;
    wr(8'hFF); wr(8'hF8); wr(8'h1F); wr(8'h7E); pulseEnd();
    bePeriod = 2; run(200);
    curReq = "R6"; run(60);

    // R7 underrun abort
    curReq = "R7"; bePeriod = 1;
    wr(8'h55); wr(8'hAA); run(100);

    // R4 raw stream
    curReq = "R4"; rawMode = 1; bePeriod = 3;
    wr(8'h81); wr(8'hC3); wr(8'h00); wr(8'hFF); run(160);

    // R5 raw end cuts the stream
    curReq = "R5"; bePeriod = 0;
    wr(8'h0F); wr(8'hF0); wr(8'h33); wr(8'hCC); wr(8'h5A); wr(8'hA5);
    bePeriod = 1; run(10); pulseEnd(); run(50);

    // R9 / R11 ready threshold and full FIFO
    curReq = "R9"; bePeriod = 0;
    for (int k = 1; k <= 10; k++) begin
      wr(8'(k * 17));
      checkBit($sformatf("R9 fifoReady after %0d writes", k), fifoReady,
               (k <= DEPTH / 2) ? 1'b1 : 1'b0);
    end
    curReq = "R11"; bePeriod = 1; run(100);

    // R8 reset during a framed message, with a write in the same cycle
    curReq = "R8"; rawMode = 0; fillFlag = 1; bePeriod = 0;
    for (int k = 0; k < 6; k++) wr(8'(8'hE0 + k));
    checkBit("R8 fifoReady before reset", fifoReady, 1'b0);
    bePeriod = 1; run(25);
    @(negedge clk); cmdReset = 1; wrEn = 1; wrData = 8'h99;
    @(negedge clk); cmdReset = 0; wrEn = 0;
    checkBit("R8 fifoReady after reset", fifoReady, 1'b1);
    run(60);

    // R12 mode change mid-frame, end discarded while idle
    curReq = "R12"; bePeriod = 0; fillFlag = 0;
    wr(8'h6B); wr(8'hFE); wr(8'h01); pulseEnd();
    bePeriod = 1; run(14); rawMode = 1; run(70);
    rawMode = 0; run(10);
    pulseEnd(); run(10);
    wr(8'hC9); run(60);

    // R10 slow bit clock
    curReq = "R10"; bePeriod = 4;
    wr(8'hF7); wr(8'h3E); pulseEnd(); run(400);

    done = 1;
    summary();
    $finish;
  end

endmodule